// File: doc/BRIEF.md
# SD Raster Timing and Subcarrier Reset Controller

This block runs the horizontal, vertical and field counters of a standard-definition raster and the 32-bit colour-subcarrier phase accumulator. A single external control pin is interpreted in one of three ways, selected by a 2-bit mode input. In the first way, it is a level-held timing reset. In the second, it is a request to clear the subcarrier phase at the next field boundary. In the third, it is a serial line carrying a new subcarrier increment, which is applied line by line.

Mode encoding is `00` for timing reset, `01` for deferred subcarrier reset, `10` for serial increment capture and `11` for idle. In idle the pin has no effect. The field sequence is eight fields long when `pal_sel` is 1 and four fields long when it is 0. The current field index is an output, where index 0 stands for the first field. Line length and lines per field are parameters, so a reduced raster can be built.

Every interface is a plain control or status pin. No data stream enters or leaves the block, so there is no valid/ready handshake and no back-pressure.

Top module: `sd_raster_phase_ctrl`

## Requirements
- R1: In mode `00`, while the synchronised pin is high, `h_count`, `v_count`, `field_idx` and `phase_acc` stay at 0.
- R2: When the pin falls in mode `00`, counting resumes from `h_count`=0, `v_count`=0, `field_idx`=0 (the first field), and the phase accumulates from 0.
- R3: The pin passes through a two-flop synchroniser. A high pulse lasting one clock is recognised, and the counters read 0 after the third rising clock edge that follows the pin going high.
- R4: In mode `01`, a rising edge on the pin changes neither the counters nor the phase at once. The phase is cleared to 0 by the clock edge at which `h_count`=0 and `v_count`=0 (the next field start), and this happens once per rising edge.
- R5: `h_count` wraps at `LINE_LEN`-1 and `v_count` wraps at `LINES_PER_FIELD`-1. `field_idx` then advances and wraps after 7 when `pal_sel`=1, or after 3 when `pal_sel`=0. `line_start` is high when `h_count`=0, and `field_start` is high when `h_count` and `v_count` are both 0.
- R6: `phase_acc` adds `active_incr` at every clock, modulo 2^32. `active_incr` equals `freq_word` in every mode except `10` after a serial word has been applied.
- R7: In mode `10`, a frame on the pin is formed as follows. The line idles low. A start bit is high for 2 clocks. Then 67 data bits follow, bit 0 first, each lasting 2 clocks. Data bits 0..21 become `active_incr[31:10]`, with `active_incr[9:0]`=0. Data bits 22..66 are ignored.
- R8: A captured increment takes effect only at the first line start after the frame completes: `active_incr` changes in the cycle in which `h_count` has just become 1.
- R9: In mode `11` the pin is ignored: the counters advance and the phase accumulates as if the pin were low.
- R10: In modes `01` and `10` the pin never holds or resets the horizontal, vertical or field counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Pin function select: 00 timing reset, 01 subcarrier reset, 10 serial increment, 11 idle |
| pal_sel | input | 1 | 1 selects an 8-field sequence, 0 selects a 4-field sequence |
| ctl_pin | input | 1 | Asynchronous control pin |
| freq_word | input | 32 | Programmed subcarrier increment |
| h_count | output | clog2(LINE_LEN) | Horizontal position |
| v_count | output | clog2(LINES_PER_FIELD) | Line within field |
| field_idx | output | 3 | Active field index, 0 is the first field |
| line_start | output | 1 | High on the first pixel of each line |
| field_start | output | 1 | High on the first pixel of each field |
| phase_acc | output | 32 | Subcarrier phase accumulator |
| active_incr | output | 32 | Increment currently added to the phase |

## Verification
The timing reset is tried with a long held pulse under four combinations of field sequence length and increment. Each combination is followed by a full field wrap, which separates the 4-field and 8-field sequences and confirms the accumulation step. A one-clock pulse tells a recognised minimum-width reset apart from a missed one. A subcarrier-reset pulse in the middle of a field separates a deferred clear from an immediate one, and a counter reset from a phase-only reset. Two serial frames tell a correct bit order and field placement from a swapped or shifted one: one frame has every ignored bit set and the other has every ignored bit clear. Each frame also has its first change of increment tied to a line start.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  typedef enum logic [1:0] {
    MODE_TRESET  = 2'b00,
    MODE_SCRESET = 2'b01,
    MODE_SERIAL  = 2'b10,
    MODE_IDLE    = 2'b11
  } ctl_mode_e;

  localparam int PHASE_W     = 32;
  localparam int SER_INC_W   = 22;
  localparam int SER_WORD_W  = 67;
endpackage

// File: rtl/sdr_pin_sync.sv
module sdr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic lvl,
  output logic rise
);
  logic lvl_q;

  generate
    if (STAGES == 1) begin : g_single
      logic sr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= 1'b0;
        else        sr <= pin_in;
      end
      assign lvl = sr;
    end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], pin_in};
      end
      assign lvl = sr[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/sdr_raster.sv
module sdr_raster #(
  parameter int LINE_LEN        = 864,
  parameter int LINES_PER_FIELD = 313,
  parameter int FIELDS_LONG     = 8,
  parameter int FIELDS_SHORT    = 4,
  localparam int HW = $clog2(LINE_LEN),
  localparam int VW = $clog2(LINES_PER_FIELD),
  localparam int FW = $clog2(FIELDS_LONG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          long_seq,
  output logic [HW-1:0] h_count,
  output logic [VW-1:0] v_count,
  output logic [FW-1:0] field_idx,
  output logic          line_start,
  output logic          field_start
);
  localparam logic [HW-1:0] H_LAST   = HW'(LINE_LEN - 1);
  localparam logic [VW-1:0] V_LAST   = VW'(LINES_PER_FIELD - 1);
  localparam logic [FW-1:0] F_LAST_L = FW'(FIELDS_LONG - 1);
  localparam logic [FW-1:0] F_LAST_S = FW'(FIELDS_SHORT - 1);

  logic h_end, v_end, f_end;

  assign h_end = (h_count == H_LAST);
  assign v_end = (v_count == V_LAST);
  assign f_end = (field_idx >= (long_seq ? F_LAST_L : F_LAST_S));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_count   <= '0;
      v_count   <= '0;
      field_idx <= '0;
    end else if (hold) begin
      h_count   <= '0;
      v_count   <= '0;
      field_idx <= '0;
    end else if (h_end) begin
      h_count <= '0;
      if (v_end) begin
        v_count   <= '0;
        field_idx <= f_end ? '0 : field_idx + FW'(1);
      end else begin
        v_count <= v_count + VW'(1);
      end
    end else begin
      h_count <= h_count + HW'(1);
    end
  end

  assign line_start  = (h_count == '0);
  assign field_start = line_start && (v_count == '0);
endmodule

// File: rtl/sdr_serial_rx.sv
module sdr_serial_rx #(
  parameter int WORD_W = 67,
  parameter int INC_W  = 22,
  localparam int LAST_CNT = 2 * WORD_W + 1,
  localparam int CW       = $clog2(LAST_CNT + 1),
  localparam int CAP_END  = 3 + 2 * INC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             lvl,
  input  logic             rise,
  input  logic             line_start,
  output logic             inc_valid,
  output logic [INC_W-1:0] inc_word
);
  logic             busy;
  logic [CW-1:0]    cnt;
  logic [INC_W-1:0] shreg;
  logic [INC_W-1:0] held;
  logic             word_ready;
  logic             sample_now;

  // second clock of each data bit; cnt counts clocks from the start bit
  assign sample_now = busy && cnt[0] && (cnt >= CW'(3)) && (cnt < CW'(CAP_END));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cnt        <= '0;
      shreg      <= '0;
      held       <= '0;
      word_ready <= 1'b0;
      inc_valid  <= 1'b0;
      inc_word   <= '0;
    end else if (!enable) begin
      busy       <= 1'b0;
      cnt        <= '0;
      word_ready <= 1'b0;
      inc_valid  <= 1'b0;
    end else begin
      if (line_start && word_ready) begin
        inc_word   <= held;
        inc_valid  <= 1'b1;
        word_ready <= 1'b0;
      end
      if (!busy) begin
        if (rise) begin
          busy <= 1'b1;
          cnt  <= CW'(1);
        end
      end else begin
        cnt <= cnt + CW'(1);
        if (sample_now) shreg <= {lvl, shreg[INC_W-1:1]};
        if (cnt == CW'(LAST_CNT)) begin
          busy       <= 1'b0;
          held       <= shreg;
          word_ready <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdr_phase_acc.sv
module sdr_phase_acc #(
  parameter int W     = 32,
  parameter int INC_W = 22,
  localparam int PAD  = W - INC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     freq_word,
  input  logic             use_serial,
  input  logic [INC_W-1:0] serial_inc,
  input  logic             clr_now,
  input  logic             sched_en,
  input  logic             sched_arm,
  input  logic             field_start,
  output logic [W-1:0]     phase,
  output logic [W-1:0]     active_incr
);
  logic pending;
  logic fire;

  assign active_incr = use_serial ? {serial_inc, {PAD{1'b0}}} : freq_word;
  assign fire        = sched_en && pending && field_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pending <= 1'b0;
    else if (!sched_en) pending <= 1'b0;
    else if (fire)      pending <= sched_arm;
    else if (sched_arm) pending <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (clr_now) phase <= '0;
    else if (fire)    phase <= '0;
    else              phase <= phase + active_incr;
  end
endmodule

// File: rtl/sd_raster_phase_ctrl.sv
module sd_raster_phase_ctrl #(
  parameter int LINE_LEN        = 864,
  parameter int LINES_PER_FIELD = 313,
  parameter int SYNC_STAGES     = 2,
  localparam int HW = $clog2(LINE_LEN),
  localparam int VW = $clog2(LINES_PER_FIELD),
  localparam int FW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          pal_sel,
  input  logic          ctl_pin,
  input  logic [31:0]   freq_word,
  output logic [HW-1:0] h_count,
  output logic [VW-1:0] v_count,
  output logic [FW-1:0] field_idx,
  output logic          line_start,
  output logic          field_start,
  output logic [31:0]   phase_acc,
  output logic [31:0]   active_incr
);
  import sdr_pkg::*;

  ctl_mode_e             cur_mode;
  logic                  pin_lvl, pin_rise;
  logic                  tr_hold, scr_en, scr_arm, ser_en;
  logic                  ser_valid;
  logic [SER_INC_W-1:0]  ser_inc;

  assign cur_mode = ctl_mode_e'(mode);
  assign tr_hold  = (cur_mode == MODE_TRESET)  && pin_lvl;
  assign scr_en   = (cur_mode == MODE_SCRESET);
  assign scr_arm  = scr_en && pin_rise;
  assign ser_en   = (cur_mode == MODE_SERIAL);

  sdr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (ctl_pin),
    .lvl    (pin_lvl),
    .rise   (pin_rise)
  );

  sdr_raster #(
    .LINE_LEN        (LINE_LEN),
    .LINES_PER_FIELD (LINES_PER_FIELD),
    .FIELDS_LONG     (8),
    .FIELDS_SHORT    (4)
  ) u_raster (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold        (tr_hold),
    .long_seq    (pal_sel),
    .h_count     (h_count),
    .v_count     (v_count),
    .field_idx   (field_idx),
    .line_start  (line_start),
    .field_start (field_start)
  );

  sdr_serial_rx #(.WORD_W(SER_WORD_W), .INC_W(SER_INC_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (ser_en),
    .lvl        (pin_lvl),
    .rise       (pin_rise),
    .line_start (line_start),
    .inc_valid  (ser_valid),
    .inc_word   (ser_inc)
  );

  sdr_phase_acc #(.W(PHASE_W), .INC_W(SER_INC_W)) u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .freq_word   (freq_word),
    .use_serial  (ser_en && ser_valid),
    .serial_inc  (ser_inc),
    .clr_now     (tr_hold),
    .sched_en    (scr_en),
    .sched_arm   (scr_arm),
    .field_start (field_start),
    .phase       (phase_acc),
    .active_incr (active_incr)
  );
endmodule

// File: rtl/sdr_ctrl_checker.sv
module sdr_ctrl_checker #(
  parameter int LINE_LEN = 864,
  parameter int HW = 10,
  parameter int VW = 9,
  parameter int FW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          pal_sel,
  input logic          pin_lvl,
  input logic          pin_rise,
  input logic [31:0]   freq_word,
  input logic [HW-1:0] h_count,
  input logic [VW-1:0] v_count,
  input logic [FW-1:0] field_idx,
  input logic          field_start,
  input logic [31:0]   phase_acc,
  input logic [31:0]   active_incr
);
  localparam logic [HW-1:0] H_LAST = HW'(LINE_LEN - 1);

  // R1
  a_r1_held_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && pin_lvl) |=>
      (h_count == '0 && v_count == '0 && field_idx == '0 && phase_acc == '0));

  // R2
  a_r2_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && !pin_lvl && $past(mode) == 2'b00 && $past(pin_lvl)) |=>
      (h_count == HW'(1) && v_count == '0 && field_idx == '0 &&
       phase_acc == $past(active_incr)));

  // R4
  a_r4_no_instant_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && pin_rise && !field_start) |=>
      (phase_acc == $past(phase_acc) + $past(active_incr)));

  // R5
  a_r5_short_range: assert property (@(posedge clk) disable iff (!rst_n)
    (!pal_sel && !$past(pal_sel) && $past(field_idx) <= FW'(3)) |->
      (field_idx <= FW'(3)));

  // R6
  a_r6_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00 && !(mode == 2'b01 && field_start)) |=>
      (phase_acc == $past(phase_acc) + $past(active_incr)));

  // R8
  a_r8_incr_at_line: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && $past(mode) == 2'b10 && $past(freq_word) == freq_word &&
     active_incr != $past(active_incr)) |-> ($past(h_count) == '0));

  // R9 and R10
  a_r10_pin_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00) |=>
      (h_count == (($past(h_count) == H_LAST) ? '0 : $past(h_count) + HW'(1))));
endmodule

bind sd_raster_phase_ctrl sdr_ctrl_checker #(
  .LINE_LEN (LINE_LEN),
  .HW       (HW),
  .VW       (VW),
  .FW       (FW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode        (mode),
  .pal_sel     (pal_sel),
  .pin_lvl     (pin_lvl),
  .pin_rise    (pin_rise),
  .freq_word   (freq_word),
  .h_count     (h_count),
  .v_count     (v_count),
  .field_idx   (field_idx),
  .field_start (field_start),
  .phase_acc   (phase_acc),
  .active_incr (active_incr)
);

// File: tb/sim_sd_raster_phase_ctrl.sv
`timescale 1ns/1ps
module sim_sd_raster_phase_ctrl;
  localparam int LL = 8;
  localparam int LPF = 3;
  localparam int HW = $clog2(LL);
  localparam int VW = $clog2(LPF);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          pal_sel = 1'b1;
  logic          ctl_pin = 1'b0;
  logic [31:0]   freq_word = 32'h0;
  logic [HW-1:0] h_count;
  logic [VW-1:0] v_count;
  logic [2:0]    field_idx;
  logic          line_start, field_start;
  logic [31:0]   phase_acc, active_incr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sd_raster_phase_ctrl #(.LINE_LEN(LL), .LINES_PER_FIELD(LPF)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pal_sel(pal_sel), .ctl_pin(ctl_pin),
    .freq_word(freq_word), .h_count(h_count), .v_count(v_count),
    .field_idx(field_idx), .line_start(line_start), .field_start(field_start),
    .phase_acc(phase_acc), .active_incr(active_incr)
  );

  // {pal_sel, freq_word}
  localparam logic [32:0] VEC [0:3] = '{
    {1'b1, 32'h0800_0001},
    {1'b0, 32'h1234_5679},
    {1'b1, 32'hFFFF_FFF3},
    {1'b0, 32'h0000_0101}
  };

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_field_start();
    for (int i = 0; i < 400; i++) begin
      tick();
      if (field_start) return;
    end
    chk("R5 field start timeout", 32'd0, 32'd1);
  endtask

  task automatic send_frame(input logic [66:0] w);
    ctl_pin = 1'b1;
    tick(2);
    for (int i = 0; i < 67; i++) begin
      ctl_pin = w[i];
      tick(2);
    end
    ctl_pin = 1'b0;
  endtask

  task automatic check_applied(input string tag, input logic [31:0] old_v,
                               input logic [31:0] exp_v);
    for (int i = 0; i < 80; i++) begin
      tick();
      if (active_incr != old_v) begin
        chk({tag, " R7 increment field"}, active_incr, exp_v);
        chk({tag, " R8 applied at line start"}, 32'(h_count), 32'd1);
        return;
      end
    end
    chk({tag, " R8 never applied"}, active_incr, exp_v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] p0;
    logic [HW-1:0] h0;
    int nf;
    tick(3);
    chk("reset h_count", 32'(h_count), 32'd0);
    chk("reset field_idx", 32'(field_idx), 32'd0);
    chk("reset phase", phase_acc, 32'd0);
    rst_n = 1'b1;
    tick(5);

    // table: held timing reset, release, accumulation, field wrap
    for (int e = 0; e < 4; e++) begin
      pal_sel = VEC[e][32];
      freq_word = VEC[e][31:0];
      nf = pal_sel ? 8 : 4;
      mode = 2'b00;
      ctl_pin = 1'b1;
      tick(4);
      chk("R1 held h", 32'(h_count), 32'd0);
      chk("R1 held v", 32'(v_count), 32'd0);
      chk("R1 held field", 32'(field_idx), 32'd0);
      chk("R1 held phase", phase_acc, 32'd0);
      ctl_pin = 1'b0;
      tick(4);
      chk("R2 resume h", 32'(h_count), 32'd2);
      chk("R2 resume field", 32'(field_idx), 32'd0);
      chk("R2 resume phase", phase_acc, freq_word * 2);
      for (int k = 0; k < 2; k++) begin
        p0 = phase_acc;
        tick();
        chk("R6 phase step", phase_acc, p0 + freq_word);
      end
      for (int k = 1; k <= nf; k++) begin
        wait_field_start();
        chk("R5 field sequence", 32'(field_idx), 32'(k % nf));
      end
    end

    // R3: one-clock pulse
    pal_sel = 1'b1;
    freq_word = 32'h0400_0003;
    for (int i = 0; i < 400 && field_idx != 3'd2; i++) tick();
    ctl_pin = 1'b1;
    tick();
    ctl_pin = 1'b0;
    tick(4);
    chk("R3 short pulse field", 32'(field_idx), 32'd0);
    chk("R3 short pulse v", 32'(v_count), 32'd0);
    chk("R3 short pulse h", 32'(h_count), 32'd2);

    // R4 / R10: deferred subcarrier clear
    mode = 2'b01;
    for (int i = 0; i < 400 && !(field_idx == 3'd2 && v_count == 1 && h_count == 2); i++) tick();
    ctl_pin = 1'b1;
    tick(2);
    ctl_pin = 1'b0;
    tick(2);
    p0 = phase_acc;
    tick();
    chk("R4 no immediate clear", phase_acc, p0 + freq_word);
    chk("R10 field kept", 32'(field_idx), 32'd2);
    wait_field_start();
    chk("R10 field advances", 32'(field_idx), 32'd3);
    tick();
    chk("R4 phase cleared", phase_acc, 32'd0);
    tick();
    chk("R4 phase resumes", phase_acc, freq_word);
    wait_field_start();
    tick();
    chk("R4 single clear", 32'(phase_acc != 0), 32'd1);

    // R9: idle mode ignores the pin
    mode = 2'b11;
    ctl_pin = 1'b1;
    tick(4);
    h0 = h_count;
    p0 = phase_acc;
    tick();
    chk("R9 h advances", 32'(h_count), 32'((int'(h0) + 1) % LL));
    chk("R9 phase advances", phase_acc, p0 + freq_word);
    ctl_pin = 1'b0;
    tick(3);

    // R7 / R8: serial increment
    mode = 2'b10;
    freq_word = 32'h0000_5555;
    tick(4);
    chk("R7 fallback before frame", active_incr, 32'h0000_5555);
    send_frame({{45{1'b1}}, 22'h2A5C3F});
    check_applied("frame1", 32'h0000_5555, {22'h2A5C3F, 10'b0});
    tick(5);
    send_frame({{45{1'b0}}, 22'h15A3C1});
    check_applied("frame2", {22'h2A5C3F, 10'b0}, {22'h15A3C1, 10'b0});
    p0 = phase_acc;
    tick();
    chk("R6 serial increment used", phase_acc, p0 + {22'h15A3C1, 10'b0});

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule